// File: doc/BRIEF.md
# Quadrature Phase Interpolator Weight Mapper

This block turns a digital phase code into the control word of a quadrature phase interpolator: one polarity select for each of the in-phase (I) and quadrature (Q) clocks, and two weight codes for the weighting DAC that mixes them. The code spans one full turn of 360 degrees. Its two most significant bits pick one of four quadrants, and the remaining bits place the output inside that quadrant. The smallest phase step is therefore one quarter turn divided by the number of positions in a quadrant. That number is a power of two, and it also equals the DAC full scale.

Two mappings are available. In the linear mapping the I and Q weights always add up to full scale. In the sinusoidal mapping the weights approximate the cosine and sine of the angle inside the quadrant, so the sum of their squares stays close to the square of full scale. The sine values come from a quarter-wave table that is computed when the design is elaborated. The cosine is read from the same table at the mirrored index. The block swaps the two weights in odd quadrants. Because of this, a clock's polarity only flips when a single code step passes a quadrant edge, and at that step the weight on that clock is zero on one side of the edge. A one-step rotation therefore never produces a phase jump.

All outputs are registered. They change only on a clock edge at which the load strobe is high, and on that edge they take the phase code and the mode select that are present. The load strobe, the mode select and the code are plain control pins. The block applies no back-pressure and has no handshake.

Top module: `pi_weight_mapper`

## Requirements
- R1: While reset is low, and after reset is released until the first load, the outputs hold phase zero: both inversion flags are 0, weight_i equals full scale (32 with default parameters) and weight_q is 0.
- R2: On any clock edge where load is 0, all four outputs keep their values, whatever the phase code and the mode select do.
- R3: A load sampled high on a rising edge is visible on the outputs right after that same edge, and not before it.
- R4: The quadrant is given by phase_code[CODE_W-1:CODE_W-2]. Quadrant 0 gives inv_i=0 and inv_q=0. Quadrant 1 gives inv_i=1 and inv_q=0. Quadrant 2 gives both flags 1. Quadrant 3 gives inv_i=0 and inv_q=1. A flag value of 1 means the clock is inverted.
- R5: With mode_sin=0 and in-quadrant position p = phase_code[CODE_W-3:0], quadrants 0 and 2 give weight_i=FS-p and weight_q=p. Quadrants 1 and 3 give weight_i=p and weight_q=FS-p. The sum is always FS = 2^(CODE_W-2).
- R6: With mode_sin=1, let S(k) = round(FS*sin(pi*k/(2*FS))), with halves rounded up. Quadrants 0 and 2 give weight_i=S(FS-p) and weight_q=S(p). Quadrants 1 and 3 give weight_i=S(p) and weight_q=S(FS-p). The sum weight_i^2+weight_q^2 stays within 2*FS of FS^2.
- R7: When two loads in a row carry codes that differ by one step modulo 2^CODE_W, which includes the wrap between the last code and zero, any inversion flag that changes has a weight of zero either before or after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Update strobe; outputs take the new code on an edge where it is high |
| mode_sin | input | 1 | 0 selects the linear mapping, 1 the sinusoidal mapping |
| phase_code | input | CODE_W | Target phase; the top two bits give the quadrant |
| inv_i | output | 1 | Inverts the I clock when 1 |
| inv_q | output | 1 | Inverts the Q clock when 1 |
| weight_i | output | CODE_W-1 | DAC weight for the I clock, 0 to FS |
| weight_q | output | CODE_W-1 | DAC weight for the Q clock, 0 to FS |

## Verification
The bench targets the quadrant edges, walking the code one step at a time forward and backward through the wrap from the last code to zero. If the weight swap in odd quadrants were missing, or if a quadrant were given the wrong polarity, a clock would change sign while still carrying full weight. The result would be a half-turn phase jump. The bench also checks the sinusoidal table against an independent sine model at the complementary index, so a table indexed without mirroring, or off by one, shows up as wrong cosine weights. Further checks cover the single-edge load latency and stimulus applied while load is low, which catch a design that updates without the strobe or that lags by a cycle.

// File: rtl/pi_map_pkg.sv
package pi_map_pkg;

  typedef enum logic [1:0] {
    QUAD_PP = 2'd0,
    QUAD_NP = 2'd1,
    QUAD_NN = 2'd2,
    QUAD_PN = 2'd3
  } quadrant_e;

  // Quarter-wave entry: round(fs * sin(pi*k/(2*fs))) by odd Taylor series.
  function automatic int sine_entry(input int k, input int fs);
    real x;
    real x2;
    real term;
    real acc;
    x    = 3.14159265358979 * real'(k) / (2.0 * real'(fs));
    x2   = x * x;
    term = x;
    acc  = x;
    for (int n = 1; n < 8; n++) begin
      term = -term * x2 / real'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    return $rtoi(real'(fs) * acc + 0.5);
  endfunction

endpackage

// File: rtl/pi_quadrant_decode.sv
module pi_quadrant_decode
  import pi_map_pkg::*;
(
  input  logic [1:0] quad_bits,
  output logic       inv_i,
  output logic       inv_q,
  output logic       swap
);
  quadrant_e quad;

  always_comb begin
    quad  = quadrant_e'(quad_bits);
    inv_i = 1'b0;
    inv_q = 1'b0;
    unique case (quad)
      QUAD_PP: begin inv_i = 1'b0; inv_q = 1'b0; end
      QUAD_NP: begin inv_i = 1'b1; inv_q = 1'b0; end
      QUAD_NN: begin inv_i = 1'b1; inv_q = 1'b1; end
      QUAD_PN: begin inv_i = 1'b0; inv_q = 1'b1; end
      default: begin inv_i = 1'b0; inv_q = 1'b0; end
    endcase
    // odd quadrants exchange rising and falling weights
    swap = quad_bits[0];
  end
endmodule

// File: rtl/pi_linear_map.sv
module pi_linear_map #(
  parameter int POS_W = 5,
  localparam int WGT_W = POS_W + 1,
  localparam int FS    = 1 << POS_W
) (
  input  logic [POS_W-1:0] pos,
  output logic [WGT_W-1:0] rise,
  output logic [WGT_W-1:0] fall
);
  always_comb begin
    rise = {1'b0, pos};
    fall = WGT_W'(FS) - {1'b0, pos};
  end
endmodule

// File: rtl/pi_sine_rom.sv
module pi_sine_rom #(
  parameter int POS_W = 5,
  localparam int WGT_W = POS_W + 1,
  localparam int FS    = 1 << POS_W
) (
  input  logic [POS_W-1:0] pos,
  output logic [WGT_W-1:0] rise,
  output logic [WGT_W-1:0] fall
);
  logic [WGT_W-1:0] table_q [FS+1];
  logic [WGT_W-1:0] mirror_idx;

  for (genvar k = 0; k <= FS; k++) begin : g_entry
    localparam int VAL = pi_map_pkg::sine_entry(k, FS);
    assign table_q[k] = WGT_W'(VAL);
  end

  always_comb begin
    mirror_idx = WGT_W'(FS) - {1'b0, pos};
    rise       = table_q[{1'b0, pos}];
    fall       = table_q[mirror_idx];
  end
endmodule

// File: rtl/pi_weight_mapper.sv
module pi_weight_mapper #(
  parameter int CODE_W = 7,
  localparam int POS_W = CODE_W - 2,
  localparam int WGT_W = POS_W + 1,
  localparam int FS    = 1 << POS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              mode_sin,
  input  logic [CODE_W-1:0] phase_code,
  output logic              inv_i,
  output logic              inv_q,
  output logic [WGT_W-1:0]  weight_i,
  output logic [WGT_W-1:0]  weight_q
);
  logic [POS_W-1:0] pos;
  logic             nxt_inv_i, nxt_inv_q, swap;
  logic [WGT_W-1:0] lin_rise, lin_fall, sin_rise, sin_fall;
  logic [WGT_W-1:0] rise, fall, nxt_wi, nxt_wq;

  assign pos = phase_code[POS_W-1:0];

  pi_quadrant_decode u_quad (
    .quad_bits (phase_code[CODE_W-1:CODE_W-2]),
    .inv_i     (nxt_inv_i),
    .inv_q     (nxt_inv_q),
    .swap      (swap)
  );

  pi_linear_map #(.POS_W(POS_W)) u_lin (
    .pos  (pos),
    .rise (lin_rise),
    .fall (lin_fall)
  );

  pi_sine_rom #(.POS_W(POS_W)) u_sin (
    .pos  (pos),
    .rise (sin_rise),
    .fall (sin_fall)
  );

  always_comb begin
    rise   = mode_sin ? sin_rise : lin_rise;
    fall   = mode_sin ? sin_fall : lin_fall;
    nxt_wi = swap ? rise : fall;
    nxt_wq = swap ? fall : rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_i    <= 1'b0;
      inv_q    <= 1'b0;
      weight_i <= WGT_W'(FS);
      weight_q <= '0;
    end else if (load) begin
      inv_i    <= nxt_inv_i;
      inv_q    <= nxt_inv_q;
      weight_i <= nxt_wi;
      weight_q <= nxt_wq;
    end
  end
endmodule

// File: rtl/pi_weight_mapper_checker.sv
module pi_weight_mapper_checker #(
  parameter int CODE_W = 7,
  localparam int POS_W = CODE_W - 2,
  localparam int WGT_W = POS_W + 1,
  localparam int FS    = 1 << POS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              mode_sin,
  input logic [CODE_W-1:0] phase_code,
  input logic              inv_i,
  input logic              inv_q,
  input logic [WGT_W-1:0]  weight_i,
  input logic [WGT_W-1:0]  weight_q
);
  logic [CODE_W-1:0] code_q;
  logic              mode_q;
  logic              adjacent;
  int                sumsq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= 1'b0;
    end else if (load) begin
      code_q <= phase_code;
      mode_q <= mode_sin;
    end
  end

  always_comb begin
    adjacent = (phase_code == code_q + CODE_W'(1)) || (code_q == phase_code + CODE_W'(1));
    sumsq    = int'(weight_i) * int'(weight_i) + int'(weight_q) * int'(weight_q);
  end

  assert_reset_value_R1: assert property (@(posedge clk)
    !rst_n |=> (!inv_i && !inv_q && weight_i == WGT_W'(FS) && weight_q == '0));

  assert_hold_no_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(inv_i) && $stable(inv_q) && $stable(weight_i) && $stable(weight_q)));

  assert_quadrant_polarity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_i == (code_q[CODE_W-1] ^ code_q[CODE_W-2])) && (inv_q == code_q[CODE_W-1]));

  assert_linear_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> (int'(weight_i) + int'(weight_q) == FS));

  assert_sine_norm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> (sumsq >= FS * FS - 2 * FS && sumsq <= FS * FS + 2 * FS));

  assert_boundary_i_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && adjacent) |=> (inv_i == $past(inv_i) || weight_i == '0 || $past(weight_i) == '0));

  assert_boundary_q_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && adjacent) |=> (inv_q == $past(inv_q) || weight_q == '0 || $past(weight_q) == '0));
endmodule

bind pi_weight_mapper pi_weight_mapper_checker #(.CODE_W(CODE_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .load       (load),
  .mode_sin   (mode_sin),
  .phase_code (phase_code),
  .inv_i      (inv_i),
  .inv_q      (inv_q),
  .weight_i   (weight_i),
  .weight_q   (weight_q)
);

// File: tb/pi_weight_mapper_test.sv
module pi_weight_mapper_test;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 7;
  localparam int FS = 32;
  localparam int NCODES = 128;
  localparam int NVEC = 13;

  typedef struct packed {
    logic       mode;
    logic [6:0] code;
    logic       ii;
    logic       iq;
    logic [5:0] wi;
    logic [5:0] wq;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 7'd0,   1'b0, 1'b0, 6'd32, 6'd0},
    '{1'b0, 7'd5,   1'b0, 1'b0, 6'd27, 6'd5},
    '{1'b0, 7'd37,  1'b1, 1'b0, 6'd5,  6'd27},
    '{1'b0, 7'd70,  1'b1, 1'b1, 6'd26, 6'd6},
    '{1'b0, 7'd127, 1'b0, 1'b1, 6'd31, 6'd1},
    '{1'b0, 7'd96,  1'b0, 1'b1, 6'd0,  6'd32},
    '{1'b1, 7'd8,   1'b0, 1'b0, 6'd30, 6'd12},
    '{1'b1, 7'd16,  1'b0, 1'b0, 6'd23, 6'd23},
    '{1'b1, 7'd40,  1'b1, 1'b0, 6'd12, 6'd30},
    '{1'b1, 7'd72,  1'b1, 1'b1, 6'd30, 6'd12},
    '{1'b1, 7'd104, 1'b0, 1'b1, 6'd12, 6'd30},
    '{1'b1, 7'd64,  1'b1, 1'b1, 6'd32, 6'd0},
    '{1'b1, 7'd31,  1'b0, 1'b0, 6'd2,  6'd32}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic       mode_sin = 1'b0;
  logic [6:0] phase_code = '0;
  logic       inv_i, inv_q;
  logic [5:0] weight_i, weight_q;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pi_weight_mapper #(.CODE_W(CODE_W)) uut (
    .clk (clk), .rst_n (rst_n), .load (load), .mode_sin (mode_sin),
    .phase_code (phase_code), .inv_i (inv_i), .inv_q (inv_q),
    .weight_i (weight_i), .weight_q (weight_q)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  function automatic int sinw(input int k);
    return $rtoi(real'(FS) * $sin(3.141592653589793 * real'(k) / (2.0 * real'(FS))) + 0.5);
  endfunction

  function automatic int model_w(input logic m, input int code, input bit want_q);
    int q = code / FS;
    int p = code % FS;
    int rise = m ? sinw(p) : p;
    int fall = m ? sinw(FS - p) : FS - p;
    if (q % 2 == 1) return want_q ? fall : rise;
    return want_q ? rise : fall;
  endfunction

  task automatic apply(input logic m, input int code);
    @(negedge clk);
    load = 1'b1;
    mode_sin = m;
    phase_code = 7'(code);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic check_polarity(input string tag, input int code);
    int q = code / FS;
    check({tag, " inv_i"}, int'(inv_i), (q == 1 || q == 2) ? 1 : 0);
    check({tag, " inv_q"}, int'(inv_q), (q >= 2) ? 1 : 0);
  endtask

  task automatic walk(input logic m, input bit fwd);
    int code = 0;
    int pi_i, pi_q, pw_i, pw_q;
    apply(m, 0);
    for (int s = 0; s <= NCODES; s++) begin
      pi_i = int'(inv_i); pi_q = int'(inv_q);
      pw_i = int'(weight_i); pw_q = int'(weight_q);
      code = fwd ? (code + 1) % NCODES : (code + NCODES - 1) % NCODES;
      apply(m, code);
      if (int'(inv_i) != pi_i)
        check("R7 flip on I needs zero weight", (weight_i == 0 || pw_i == 0) ? 1 : 0, 1);
      if (int'(inv_q) != pi_q)
        check("R7 flip on Q needs zero weight", (weight_q == 0 || pw_q == 0) ? 1 : 0, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: values during reset
    repeat (3) @(negedge clk);
    check("R1 reset inv_i", int'(inv_i), 0);
    check("R1 reset inv_q", int'(inv_q), 0);
    check("R1 reset weight_i", int'(weight_i), FS);
    check("R1 reset weight_q", int'(weight_q), 0);
    rst_n = 1'b1;
    phase_code = 7'd50;
    mode_sin = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release weight_i", int'(weight_i), FS);
    check("R1 after release inv_i", int'(inv_i), 0);

    // table walk: R4 polarity, R5 linear, R6 sinusoidal
    for (int v = 0; v < NVEC; v++) begin
      apply(VEC[v].mode, int'(VEC[v].code));
      check("R4 table inv_i", int'(inv_i), int'(VEC[v].ii));
      check("R4 table inv_q", int'(inv_q), int'(VEC[v].iq));
      check(VEC[v].mode ? "R6 table weight_i" : "R5 table weight_i", int'(weight_i), int'(VEC[v].wi));
      check(VEC[v].mode ? "R6 table weight_q" : "R5 table weight_q", int'(weight_q), int'(VEC[v].wq));
    end

    // R3: not visible before the edge, visible right after it
    apply(1'b0, 0);
    @(negedge clk);
    load = 1'b1; mode_sin = 1'b0; phase_code = 7'd37;
    #1;
    check("R3 before edge weight_i", int'(weight_i), FS);
    @(posedge clk);
    #1;
    load = 1'b0;
    check("R3 after edge weight_i", int'(weight_i), 5);
    check("R3 after edge inv_i", int'(inv_i), 1);

    // R2: stimulus with load low has no effect
    @(negedge clk);
    phase_code = 7'd100; mode_sin = 1'b1;
    repeat (3) @(negedge clk);
    phase_code = 7'd3;
    @(negedge clk);
    check("R2 hold weight_i", int'(weight_i), 5);
    check("R2 hold weight_q", int'(weight_q), 27);
    check("R2 hold inv_i", int'(inv_i), 1);
    check("R2 hold inv_q", int'(inv_q), 0);

    // full sweeps against the model
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < NCODES; c++) begin
        apply(m[0], c);
        check_polarity("R4 sweep", c);
        check(m ? "R6 sweep weight_i" : "R5 sweep weight_i", int'(weight_i), model_w(m[0], c, 1'b0));
        check(m ? "R6 sweep weight_q" : "R5 sweep weight_q", int'(weight_q), model_w(m[0], c, 1'b1));
      end
    end

    // R7: single-step walks in both directions through the wrap
    walk(1'b0, 1'b1);
    walk(1'b0, 1'b0);
    walk(1'b1, 1'b1);
    walk(1'b1, 1'b0);

    // R1: reset in the middle of operation
    apply(1'b1, 72);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 midrun weight_i", int'(weight_i), FS);
    check("R1 midrun weight_q", int'(weight_q), 0);
    check("R1 midrun inv_i", int'(inv_i), 0);
    check("R1 midrun inv_q", int'(inv_q), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule